// File: doc/BRIEF.md
# Radio SPI Session Sequencer

This block sits between a controller and a byte-wide SPI shifter that talks to a short-range packet radio. A single request (kind, register address, burst length) becomes one complete chip-select session. The block forms the leading header byte, drives the active-low select for the whole session and feeds every byte to the shifter through a start/done handshake. It keeps the status byte that the radio returns while the header shifts out.

Payload travels on two valid/ready streams. Write data (configuration words and transmit FIFO payload) enters on the `tx_*` stream. Data read back (register contents and receive FIFO bytes) leaves on the `rx_*` stream. Back-pressure on either stream pauses the session between bytes, with chip select held low and no shift started. A byte on `rx_data` stays stable while `rx_valid` is high and `rx_ready` is low. The request port is valid/ready as well: it is ready only when the block is idle and the request is allowed to start. While a request is held, it must stay unchanged.

Request kinds on `req_kind` are: 0 register write, 1 register read, 2 command strobe, 3 transmit FIFO write, 4 receive FIFO read. Codes 5 to 7 are treated as a strobe.

Top module: `radio_spi_seq`

## Requirements
- R1: The header byte has bit 7 = 0 and bit 6 = 1 for reads, 0 for writes. Bits 5:0 hold the register address. Register kinds and strobes take `req_addr`. FIFO kinds use the fixed address 0x3E (transmit) or 0x3F (receive), so their headers are 0x3E and 0x7F.
- R2: A register write shifts the header followed by exactly two bytes taken from the `tx_*` stream, whatever `req_len` says. Bytes returned during those two data bytes never appear on `rx_*` and do not change `status`.
- R3: A command strobe shifts only the header byte, then ends the session. Address 0x00 is accepted like any other strobe.
- R4: The byte the shifter returns during the header is loaded into `status` and held there until the header of the next session completes.
- R5: A transmit FIFO write shifts the header and then `req_len` bytes from the `tx_*` stream, in order. `req_len` = 0 gives a header-only session. While `tx_valid` is low, no shift is started and chip select stays low.
- R6: Reads shift 0x00 after the header: two bytes for a register read, or `req_len` bytes for a receive FIFO read. Each returned byte is offered on `rx_*` in order. It is held stable under back-pressure, and the next byte is not shifted until it is taken.
- R7: While `fifo_nonempty` is low, a receive FIFO read request is not accepted (`req_ready` low) and chip select stays high.
- R8: After reset, chip select is high. It goes low on the cycle after a request is accepted and stays low until the last byte of the session is done. Every shifter start falls inside a session. Between sessions chip select stays high for at least two clocks, and requests are accepted only when idle.
- R9: `busy` is low after reset. It is high from the cycle after acceptance and stays high while chip select is low, through the gap that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 3 | Request kind code |
| req_addr | input | 6 | Register or strobe address |
| req_len | input | LEN_W | Burst length for FIFO kinds |
| tx_valid | input | 1 | Write payload byte offered |
| tx_ready | output | 1 | Payload byte taken this cycle |
| tx_data | input | 8 | Write payload byte |
| rx_valid | output | 1 | Read byte offered |
| rx_ready | input | 1 | Consumer takes the read byte |
| rx_data | output | 8 | Read byte |
| fifo_nonempty | input | 1 | Radio receive FIFO holds data |
| status | output | 8 | Last captured status byte |
| busy | output | 1 | Session in progress |
| sh_start | output | 1 | Start one byte shift |
| sh_tx | output | 8 | Byte to shift out |
| sh_done | input | 1 | Shift finished, sh_rx valid |
| sh_rx | input | 8 | Byte shifted in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench runs each request kind against a shifter model whose reply bytes follow a known numeric sequence. A mismatch in the expected outgoing bytes shows a wrong header encoding, a wrong byte count or a wrong data order. The expected returned bytes tell captured status apart from read data. Transmit bursts run with stalls on the payload stream and receive bursts with back-pressure, which shows that pauses neither drop nor repeat bytes. A register write followed by a strobe shows that write-time replies are discarded. A held receive request with the FIFO flag low, then released, separates blocking from acceptance. Header-only sessions of both kinds (a strobe, and a transmit burst of length zero) check that the select closes right after the header.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [2:0] {
    K_CFG_WR = 3'd0,
    K_REG_RD = 3'd1,
    K_STROBE = 3'd2,
    K_TXF_WR = 3'd3,
    K_RXF_RD = 3'd4
  } req_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_HWAIT,
    S_PICK,
    S_DWAIT,
    S_PUSH,
    S_GAP
  } seq_state_e;

endpackage

// File: rtl/rss_req_decode.sv
module rss_req_decode
  import rss_pkg::*;
#(
  parameter int          LEN_W     = 8,
  parameter int          REG_BYTES = 2,
  parameter logic [5:0]  TXF_ADDR  = 6'h3E,
  parameter logic [5:0]  RXF_ADDR  = 6'h3F
) (
  input  logic [2:0]       kind,
  input  logic [5:0]       addr,
  input  logic [LEN_W-1:0] len,
  output logic [7:0]       hdr,
  output logic             is_rd,
  output logic [LEN_W-1:0] nbytes
);
  localparam logic [LEN_W-1:0] REG_N = LEN_W'(REG_BYTES);

  // R1: bit 7 clear, bit 6 = read, bits 5:0 = address
  always_comb begin
    case (req_kind_e'(kind))
      K_CFG_WR: begin hdr = {2'b00, addr};     is_rd = 1'b0; nbytes = REG_N; end
      K_REG_RD: begin hdr = {2'b01, addr};     is_rd = 1'b1; nbytes = REG_N; end
      K_TXF_WR: begin hdr = {2'b00, TXF_ADDR}; is_rd = 1'b0; nbytes = len;   end
      K_RXF_RD: begin hdr = {2'b01, RXF_ADDR}; is_rd = 1'b1; nbytes = len;   end
      default:  begin hdr = {2'b00, addr};     is_rd = 1'b0; nbytes = '0;    end
    endcase
  end
endmodule

// File: rtl/rss_cs_gap.sv
module rss_cs_gap #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int CW = $clog2(GAP + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(GAP);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt <= CW'(1));
endmodule

// File: rtl/rss_fsm.sv
module rss_fsm
  import rss_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  output logic             req_ready,
  input  logic [7:0]       dec_hdr,
  input  logic             dec_rd,
  input  logic [LEN_W-1:0] dec_n,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  input  logic             fifo_nonempty,
  output logic [7:0]       status,
  output logic             busy,
  output logic             sh_start,
  output logic [7:0]       sh_tx,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx,
  output logic             cs_n,
  output logic             gap_load,
  input  logic             gap_done
);
  seq_state_e       state, nxt;
  logic [LEN_W-1:0] rem;
  logic             rd_q;
  logic [7:0]       hdr_q, rxbuf, status_q;
  logic             cs_n_q;
  logic             fire, rx_blocked;

  assign rx_blocked = (req_kind_e'(req_kind) == K_RXF_RD) && !fifo_nonempty;
  assign req_ready  = (state == S_IDLE) && !rx_blocked;
  assign fire       = req_valid && req_ready;

  always_comb begin
    nxt      = state;
    sh_start = 1'b0;
    sh_tx    = hdr_q;
    tx_ready = 1'b0;
    gap_load = 1'b0;
    case (state)
      S_IDLE:  if (fire) nxt = S_HDR;
      S_HDR: begin
        sh_start = 1'b1;
        nxt      = S_HWAIT;
      end
      S_HWAIT: if (sh_done) begin
        if (rem == '0) begin nxt = S_GAP; gap_load = 1'b1; end
        else nxt = S_PICK;
      end
      S_PICK: begin
        if (rd_q) begin
          sh_start = 1'b1;
          sh_tx    = 8'h00;
          nxt      = S_DWAIT;
        end else begin
          tx_ready = 1'b1;
          sh_tx    = tx_data;
          if (tx_valid) begin
            sh_start = 1'b1;
            nxt      = S_DWAIT;
          end
        end
      end
      S_DWAIT: if (sh_done) begin
        if (rd_q) nxt = S_PUSH;
        else if (rem == LEN_W'(1)) begin nxt = S_GAP; gap_load = 1'b1; end
        else nxt = S_PICK;
      end
      S_PUSH: if (rx_ready) begin
        if (rem == '0) begin nxt = S_GAP; gap_load = 1'b1; end
        else nxt = S_PICK;
      end
      S_GAP:   if (gap_done) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      rem      <= '0;
      rd_q     <= 1'b0;
      hdr_q    <= 8'h00;
      rxbuf    <= 8'h00;
      status_q <= 8'h00;
      cs_n_q   <= 1'b1;
    end else begin
      state <= nxt;
      if (fire) begin
        hdr_q  <= dec_hdr;
        rd_q   <= dec_rd;
        rem    <= dec_n;
        cs_n_q <= 1'b0;
      end
      if (gap_load) cs_n_q <= 1'b1;
      if (state == S_HWAIT && sh_done) status_q <= sh_rx;
      if (state == S_DWAIT && sh_done) begin
        rem <= rem - 1'b1;
        if (rd_q) rxbuf <= sh_rx;
      end
    end
  end

  assign rx_valid = (state == S_PUSH);
  assign rx_data  = rxbuf;
  assign status   = status_q;
  assign busy     = (state != S_IDLE);
  assign cs_n     = cs_n_q;

  // R9: select low only inside a busy session
  p_cs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> busy);
  // R8: shifter starts only with select low
  p_start_in_session_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> !cs_n_q);
  // R8: select stays high at least two clocks
  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |=> cs_n_q);
  // R7: held receive request with empty FIFO keeps select high
  p_rx_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && req_valid && rx_blocked) |=> cs_n_q);
  // R6: read byte held under back-pressure
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  // R2: no read data offered in a write session
  p_no_rx_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rd_q);
  // R4: status only moves after a header completes
  p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_HWAIT) |=> $stable(status_q));
endmodule

// File: rtl/radio_spi_seq.sv
module radio_spi_seq
  import rss_pkg::*;
#(
  parameter int         LEN_W     = 8,
  parameter int         CS_GAP    = 2,
  parameter int         REG_BYTES = 2,
  parameter logic [5:0] TXF_ADDR  = 6'h3E,
  parameter logic [5:0] RXF_ADDR  = 6'h3F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic [5:0]       req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  input  logic             fifo_nonempty,
  output logic [7:0]       status,
  output logic             busy,
  output logic             sh_start,
  output logic [7:0]       sh_tx,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx,
  output logic             cs_n
);
  logic [7:0]       dec_hdr;
  logic             dec_rd;
  logic [LEN_W-1:0] dec_n;
  logic             gap_load, gap_done;

  rss_req_decode #(
    .LEN_W(LEN_W), .REG_BYTES(REG_BYTES), .TXF_ADDR(TXF_ADDR), .RXF_ADDR(RXF_ADDR)
  ) u_dec (
    .kind(req_kind), .addr(req_addr), .len(req_len),
    .hdr(dec_hdr), .is_rd(dec_rd), .nbytes(dec_n)
  );

  rss_cs_gap #(.GAP(CS_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .done(gap_done)
  );

  rss_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_ready(req_ready),
    .dec_hdr(dec_hdr), .dec_rd(dec_rd), .dec_n(dec_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .fifo_nonempty(fifo_nonempty), .status(status), .busy(busy),
    .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx),
    .cs_n(cs_n), .gap_load(gap_load), .gap_done(gap_done)
  );
endmodule

// File: tb/radio_spi_seq_tb.sv
module radio_spi_seq_tb;
  import rss_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       req_valid = 1'b0, req_ready;
  logic [2:0] req_kind = 3'd2;
  logic [5:0] req_addr = 6'd0;
  logic [7:0] req_len = 8'd0;
  logic       tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic       rx_valid, rx_ready = 1'b1;
  logic [7:0] rx_data, status;
  logic       fifo_nonempty = 1'b1, busy;
  logic       sh_start, sh_done = 1'b0, cs_n;
  logic [7:0] sh_tx, sh_rx = 8'h00;

  radio_spi_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .fifo_nonempty(fifo_nonempty), .status(status), .busy(busy),
    .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx),
    .cs_n(cs_n)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  string cur_tag = "R1";
  logic [7:0] mosi_q[$];
  logic [7:0] rxe_q[$];
  logic [7:0] tx_q[$];
  bit tx_stall = 0, rx_bp = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int n);
    return 8'((n * 37 + 11) & 255);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // shifter model: three-cycle shift, replies follow resp(n)
  int mdl_n = 0;
  int mdl_busy = 0;
  always @(posedge clk) begin
    sh_done <= 1'b0;
    if (!rst_n) begin
      mdl_n <= 0; mdl_busy <= 0;
    end else if (sh_start) begin
      chk(mdl_busy == 0 && !cs_n, "R8 start while idle shifter, select low", int'(cs_n), 0);
      if (mosi_q.size() == 0) chk(1'b0, {cur_tag, " unexpected shift"}, int'(sh_tx), -1);
      else begin
        chk(sh_tx == mosi_q[0], {cur_tag, " R1 outgoing byte"}, int'(sh_tx), int'(mosi_q[0]));
        void'(mosi_q.pop_front());
      end
      mdl_busy <= 3;
    end else if (mdl_busy != 0) begin
      mdl_busy <= mdl_busy - 1;
      if (mdl_busy == 1) begin
        sh_done <= 1'b1;
        sh_rx   <= resp(mdl_n);
        mdl_n   <= mdl_n + 1;
      end
    end
  end

  // transmit payload source
  bit tx_fire = 0;
  always @(posedge clk) tx_fire <= tx_valid && tx_ready;
  always @(negedge clk) begin
    if (tx_fire && tx_q.size() > 0) void'(tx_q.pop_front());
    tx_valid = (tx_q.size() > 0) && !(tx_stall && cyc[1]);
    tx_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
  end

  // read stream monitor (scoreboard pop)
  always @(negedge clk) begin
    rx_ready = !(rx_bp && cyc[0]);
    #1;
    if (rst_n && rx_valid && rx_ready) begin
      if (rxe_q.size() == 0) chk(1'b0, {cur_tag, " R2 R6 unexpected read byte"}, int'(rx_data), -1);
      else begin
        chk(rx_data == rxe_q[0], "R6 read byte", int'(rx_data), int'(rxe_q[0]));
        void'(rxe_q.pop_front());
      end
    end
  end

  // select gap and busy monitor
  int hi_run = 0;
  bit seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n) hi_run++;
      else begin
        if (!busy) chk(1'b0, "R9 busy low with select low", 0, 1);
        if (hi_run > 0 && seen) chk(hi_run >= 2, "R8 select high gap", hi_run, 2);
        seen = 1;
        hi_run = 0;
      end
    end
  end

  int pred_n = 0;

  task automatic run(input logic [2:0] k, input logic [5:0] a, input int n,
                     input logic [7:0] hdr, input logic [7:0] seed, input string tag);
    int nb;
    logic [7:0] exp_st;
    cur_tag = tag;
    exp_st = resp(pred_n);
    pred_n++;
    mosi_q.push_back(hdr);
    nb = (k == K_CFG_WR || k == K_REG_RD) ? 2 : (k == K_STROBE ? 0 : n);
    for (int i = 0; i < nb; i++) begin
      if (k == K_REG_RD || k == K_RXF_RD) begin
        mosi_q.push_back(8'h00);
        rxe_q.push_back(resp(pred_n));
      end else begin
        mosi_q.push_back(8'(seed + i * 13));
        tx_q.push_back(8'(seed + i * 13));
      end
      pred_n++;
    end
    @(negedge clk);
    req_kind = k; req_addr = a; req_len = 8'(n); req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !cs_n, {tag, " R9 busy after accept"}, int'(busy), 1);
    while (busy) @(negedge clk);
    chk(cs_n, {tag, " R8 select high at end"}, int'(cs_n), 1);
    chk(status == exp_st, {tag, " R4 status"}, int'(status), int'(exp_st));
    chk(mosi_q.size() == 0, {tag, " byte count"}, mosi_q.size(), 0);
    chk(rxe_q.size() == 0 && tx_q.size() == 0, {tag, " streams drained"},
        rxe_q.size() + tx_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cs_n == 1'b1, "R8 reset select", int'(cs_n), 1);
    chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
    chk(rx_valid == 1'b0 && sh_start == 1'b0, "R8 reset outputs", int'(rx_valid), 0);
    chk(status == 8'h00, "R4 reset status", int'(status), 0);

    run(K_STROBE, 6'h00, 0, 8'h00, 8'h00, "R3 noop strobe");
    run(K_CFG_WR, 6'h12, 9, 8'h12, 8'h34, "R2 register write");
    run(K_STROBE, 6'h06, 0, 8'h06, 8'h00, "R3 strobe");
    run(K_REG_RD, 6'h13, 0, 8'h53, 8'h00, "R6 register read");
    tx_stall = 1;
    run(K_TXF_WR, 6'h01, 4, 8'h3E, 8'hC1, "R5 tx burst stalled");
    tx_stall = 0;
    rx_bp = 1;
    run(K_RXF_RD, 6'h02, 3, 8'h7F, 8'h00, "R6 rx burst back-pressured");
    rx_bp = 0;

    // R7: receive request held while FIFO flag low
    fifo_nonempty = 1'b0;
    @(negedge clk);
    req_kind = K_RXF_RD; req_len = 8'd2; req_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1;
      chk(!req_ready && cs_n && !busy, "R7 blocked on empty FIFO", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    fifo_nonempty = 1'b1;
    run(K_RXF_RD, 6'h00, 2, 8'h7F, 8'h00, "R7 rx after FIFO fills");

    run(K_TXF_WR, 6'h00, 0, 8'h3E, 8'h00, "R5 zero-length tx");
    run(K_CFG_WR, 6'h2A, 0, 8'h2A, 8'h90, "R2 register write back-to-back");

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule